// File: doc/BRIEF.md
# Byte-Addressed NVRAM with BCD Time-of-Day Clock

This block is a small byte-addressed storage array. Its eight highest byte locations double as a time-of-day clock. A simple synchronous bus reads and writes any byte. A one-cycle pulse on the seconds input, once per second, advances a set of packed-BCD counters for seconds, minutes, hours, day of week, date, month and year. The counters understand month lengths, including a 29-day February in years divisible by four.

While the control byte allows it, the counters are copied into the clock bytes one cycle after every tick. Software can set either of the two top bits of the control byte to freeze that copy and read a stable snapshot. The counters keep running while the copy is frozen. To set the time, software first writes the control byte with its top bit set. It then writes the desired values into the clock bytes. A control write that clears the top bit then loads those bytes into the counters. All other bytes are ordinary read/write storage, and an address past the end of the array wraps around modulo the array size.

Top module: `nvram_rtc`

## Requirements
- R1: A bus write stores its data byte at the addressed location. A read enable returns that location's contents on the read data port one clock edge later.
- R2: The byte index is the bus address modulo MEM_BYTES, so addresses past the end of the array wrap back to index zero.
- R3: The clock bytes sit at fixed offsets below the top of the array. They are year at MEM_BYTES-1, month at -2, date at -3, day of week at -4, hours at -5, minutes at -6, seconds at -7, and control at -8. Each holds packed BCD, with the tens digit in bits 7:4 and the units digit in bits 3:0.
- R4: Seconds and minutes roll from 59 to 00 and hours from 23 to 00, each carrying into the next field.
- R5: The date rolls over to 01 after the last day of the month. That day is the 30th for months 04, 06, 09 and 11, the 28th for February (the 29th when the year is divisible by four), and the 31st otherwise. The month rolls from 12 to 01, and the year rolls from 99 to 00.
- R6: Day of week counts 1 to 7. It advances whenever the date advances, and it rolls from 7 back to 1.
- R7: While bit 7 or bit 6 of the control byte is set, ticks do not change the clock bytes, but the counters keep counting.
- R8: A write to the control byte with bit 7 clear, made while the stored bit 7 is set, loads the clock bytes into the counters. Any other control write only stores the byte.
- R9: A bus write in the same cycle as a clock-byte refresh wins at its own location. The other clock bytes are still refreshed.
- R10: Reset clears every byte of the array and sets the counters to 00:00:00, date 01, month 01, year 00, day of week 1.
- R11: The clock bytes take the new counter values on the second clock edge after the edge that samples the tick. A read issued in the cycle between those two edges still returns the old value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sec_tick | input | 1 | One-cycle pulse per elapsed second |
| bus_addr | input | ADDR_W | Byte address, taken modulo MEM_BYTES |
| bus_we | input | 1 | Write enable |
| bus_wdata | input | 8 | Write data |
| bus_re | input | 1 | Read enable |
| bus_rdata | output | 8 | Read data, valid one edge after the read enable |

## Verification
The bench builds the block with MEM_BYTES = 48 and ADDR_W = 8. A size that is not a power of two selects the true modulo decoder instead of the bit slice. An 8-bit address can also reach indices several array lengths past the end, so the wrap is checked with addresses well beyond 48. With 48 bytes, the clock bytes and the control byte land at indices 40 to 47, away from any power-of-two boundary. This lets the bench show that their placement follows the parameter and not the address width.

// File: rtl/nvram_rtc_pkg.sv
package nvram_rtc_pkg;

   typedef struct packed {
      logic [7:0] year;
      logic [7:0] month;
      logic [7:0] date;
      logic [7:0] dow;
      logic [7:0] hour;
      logic [7:0] minute;
      logic [7:0] second;
   } rtc_time_t;

   localparam rtc_time_t RTC_RESET = '{year: 8'h00, month: 8'h01, date: 8'h01,
                                       dow: 8'h01, hour: 8'h00, minute: 8'h00,
                                       second: 8'h00};

   // number of clock bytes plus the control byte
   localparam int unsigned RTC_SLOTS = 8;

   function automatic logic [7:0] bcd_inc(input logic [7:0] v);
      if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
      return {v[7:4], v[3:0] + 4'd1};
   endfunction

   // divisible by four: even tens need units 0/4/8, odd tens need 2/6
   function automatic logic bcd_leap(input logic [7:0] y);
      if (y[4]) return (y[3:0] == 4'd2) || (y[3:0] == 4'd6);
      return (y[3:0] == 4'd0) || (y[3:0] == 4'd4) || (y[3:0] == 4'd8);
   endfunction

   function automatic logic [7:0] bcd_month_len(input logic [7:0] m, input logic [7:0] y);
      case (m)
         8'h02:                      return bcd_leap(y) ? 8'h29 : 8'h28;
         8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
         default:                    return 8'h31;
      endcase
   endfunction

   // field for the byte lying 'from_top' locations below the array end
   function automatic logic [7:0] rtc_field(input rtc_time_t t, input int unsigned from_top);
      case (from_top)
         1:       return t.year;
         2:       return t.month;
         3:       return t.date;
         4:       return t.dow;
         5:       return t.hour;
         6:       return t.minute;
         7:       return t.second;
         default: return 8'h00;
      endcase
   endfunction

endpackage

// File: rtl/nvram_rtc_wrap.sv
module nvram_rtc_wrap #(
   parameter int unsigned ADDR_W    = 8,
   parameter int unsigned MEM_BYTES = 64,
   parameter int unsigned IDX_W     = $clog2(MEM_BYTES)
) (
   input  logic [ADDR_W-1:0] addr,
   output logic [IDX_W-1:0]  idx
);

   localparam bit POW2 = ((MEM_BYTES & (MEM_BYTES - 1)) == 0);

   generate
      if (POW2) begin : g_slice
         assign idx = addr[IDX_W-1:0];
      end else begin : g_modulo
         localparam logic [ADDR_W-1:0] SIZE_A = ADDR_W'(MEM_BYTES);
         logic [ADDR_W-1:0] rem;
         assign rem = addr % SIZE_A;
         assign idx = rem[IDX_W-1:0];
      end
   endgenerate

   always_comb begin
      if (!$isunknown(addr)) begin
         p_idx_in_range_r2: assert (32'(idx) < MEM_BYTES)
            else $error("wrapped index out of range");
      end
   end

endmodule

// File: rtl/nvram_rtc_count.sv
module nvram_rtc_count
   import nvram_rtc_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      tick,
   input  logic      load,
   input  rtc_time_t load_val,
   output rtc_time_t now
);

   rtc_time_t  nxt;
   logic       c_sec, c_min, c_hour, c_day, c_mon;
   logic [7:0] mlen;

   always_comb begin
      nxt    = now;
      mlen   = bcd_month_len(now.month, now.year);
      c_sec  = (now.second >= 8'h59);
      c_min  = c_sec && (now.minute >= 8'h59);
      c_hour = c_min && (now.hour >= 8'h23);
      c_day  = c_hour && (now.date >= mlen);
      c_mon  = c_day && (now.month >= 8'h12);

      nxt.second = c_sec ? 8'h00 : bcd_inc(now.second);
      if (c_sec)  nxt.minute = (now.minute >= 8'h59) ? 8'h00 : bcd_inc(now.minute);
      if (c_min)  nxt.hour   = (now.hour >= 8'h23) ? 8'h00 : bcd_inc(now.hour);
      if (c_hour) begin
         nxt.date = c_day ? 8'h01 : bcd_inc(now.date);
         nxt.dow  = (now.dow >= 8'h07) ? 8'h01 : bcd_inc(now.dow);
      end
      if (c_day)  nxt.month  = c_mon ? 8'h01 : bcd_inc(now.month);
      if (c_mon)  nxt.year   = (now.year >= 8'h99) ? 8'h00 : bcd_inc(now.year);
   end

   always_ff @(posedge clk) begin
      if (!rst_n)     now <= RTC_RESET;
      else if (load)  now <= load_val;
      else if (tick)  now <= nxt;
   end

   p_sec_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !load && now.second == 8'h59) |=> (now.second == 8'h00));

   p_dow_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !load && now.dow == 8'h07 && now.hour == 8'h23 &&
       now.minute == 8'h59 && now.second == 8'h59) |=> (now.dow == 8'h01));

   p_year_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !load && now.month == 8'h12 && now.date == 8'h31 &&
       now.hour == 8'h23 && now.minute == 8'h59 && now.second == 8'h59)
      |=> (now.month == 8'h01 && now.date == 8'h01 && now.year == bcd_inc($past(now.year))
           || $past(now.year) == 8'h99 && now.year == 8'h00));

endmodule

// File: rtl/nvram_rtc_store.sv
module nvram_rtc_store
   import nvram_rtc_pkg::*;
#(
   parameter int unsigned MEM_BYTES = 64,
   parameter int unsigned IDX_W     = $clog2(MEM_BYTES)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] wr_idx,
   input  logic [7:0]       wr_data,
   input  logic             rd_en,
   input  logic [IDX_W-1:0] rd_idx,
   output logic [7:0]       rd_data,
   input  logic             refresh_en,
   input  rtc_time_t        refresh_val,
   output logic [7:0]       ctrl_byte,
   output rtc_time_t        clock_bytes
);

   localparam int unsigned CLK_LO = MEM_BYTES - (RTC_SLOTS - 1);

   logic [7:0] mem [MEM_BYTES];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < MEM_BYTES; i++) mem[i] <= 8'h00;
         rd_data <= 8'h00;
      end else begin
         for (int i = 0; i < MEM_BYTES; i++) begin
            if (wr_en && wr_idx == IDX_W'(i))
               mem[i] <= wr_data;
            else if (refresh_en && i >= CLK_LO)
               mem[i] <= rtc_field(refresh_val, MEM_BYTES - i);
         end
         if (rd_en) rd_data <= mem[rd_idx];
      end
   end

   assign ctrl_byte          = mem[MEM_BYTES - RTC_SLOTS];
   assign clock_bytes.year   = mem[MEM_BYTES - 1];
   assign clock_bytes.month  = mem[MEM_BYTES - 2];
   assign clock_bytes.date   = mem[MEM_BYTES - 3];
   assign clock_bytes.dow    = mem[MEM_BYTES - 4];
   assign clock_bytes.hour   = mem[MEM_BYTES - 5];
   assign clock_bytes.minute = mem[MEM_BYTES - 6];
   assign clock_bytes.second = mem[MEM_BYTES - 7];

   p_bus_write_r1: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> (mem[$past(wr_idx)] == $past(wr_data)));

   p_bus_over_refresh_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && refresh_en) |=> (mem[$past(wr_idx)] == $past(wr_data)));

endmodule

// File: rtl/nvram_rtc.sv
module nvram_rtc
   import nvram_rtc_pkg::*;
#(
   parameter int unsigned MEM_BYTES = 64,
   parameter int unsigned ADDR_W    = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sec_tick,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_we,
   input  logic [7:0]        bus_wdata,
   input  logic              bus_re,
   output logic [7:0]        bus_rdata
);

   localparam int unsigned IDX_W    = $clog2(MEM_BYTES);
   localparam int unsigned CTRL_IDX = MEM_BYTES - RTC_SLOTS;

   generate
      if (MEM_BYTES < RTC_SLOTS) begin : g_bad_size
         $error("MEM_BYTES must leave room for the clock and control bytes");
      end
      if (ADDR_W < IDX_W) begin : g_bad_addr
         $error("ADDR_W too narrow to reach every byte");
      end
   endgenerate

   logic [IDX_W-1:0] idx;
   logic [7:0]       ctrl_byte;
   rtc_time_t        clock_bytes;
   rtc_time_t        time_now;
   logic             refresh_pend;
   logic             refresh_en;
   logic             load_now;

   nvram_rtc_wrap #(
      .ADDR_W   (ADDR_W),
      .MEM_BYTES(MEM_BYTES),
      .IDX_W    (IDX_W)
   ) u_wrap (
      .addr(bus_addr),
      .idx (idx)
   );

   assign load_now = bus_we && (idx == IDX_W'(CTRL_IDX)) && !bus_wdata[7] && ctrl_byte[7];

   always_ff @(posedge clk) begin
      if (!rst_n) refresh_pend <= 1'b0;
      else        refresh_pend <= sec_tick;
   end

   assign refresh_en = refresh_pend && (ctrl_byte[7:6] == 2'b00);

   nvram_rtc_count u_count (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick    (sec_tick),
      .load    (load_now),
      .load_val(clock_bytes),
      .now     (time_now)
   );

   nvram_rtc_store #(
      .MEM_BYTES(MEM_BYTES),
      .IDX_W    (IDX_W)
   ) u_store (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en      (bus_we),
      .wr_idx     (idx),
      .wr_data    (bus_wdata),
      .rd_en      (bus_re),
      .rd_idx     (idx),
      .rd_data    (bus_rdata),
      .refresh_en (refresh_en),
      .refresh_val(time_now),
      .ctrl_byte  (ctrl_byte),
      .clock_bytes(clock_bytes)
   );

   p_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ((ctrl_byte[7:6] != 2'b00) && !bus_we) |=> $stable(clock_bytes));

   p_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
      load_now |=> (time_now == $past(clock_bytes)));

   p_mirror_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (refresh_en && !bus_we) |=> (clock_bytes == $past(time_now)));

   p_refresh_after_tick_r11: assert property (@(posedge clk) disable iff (!rst_n)
      refresh_en |-> $past(sec_tick));

endmodule

// File: tb/nvram_rtc_bench.sv
module nvram_rtc_bench;

   localparam int MEM    = 48;
   localparam int AW     = 8;
   localparam int A_CTRL = MEM - 8;
   localparam int A_SEC  = MEM - 7;
   localparam int A_MIN  = MEM - 6;
   localparam int A_HOUR = MEM - 5;
   localparam int A_DOW  = MEM - 4;
   localparam int A_DATE = MEM - 3;
   localparam int A_MON  = MEM - 2;
   localparam int A_YEAR = MEM - 1;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          sec_tick = 1'b0;
   logic [AW-1:0] bus_addr = '0;
   logic          bus_we = 1'b0;
   logic [7:0]    bus_wdata = 8'h00;
   logic          bus_re = 1'b0;
   logic [7:0]    bus_rdata;

   always #4 clk = ~clk;

   nvram_rtc #(.MEM_BYTES(MEM), .ADDR_W(AW)) u_nvram_rtc (
      .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .bus_addr(bus_addr),
      .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_re(bus_re), .bus_rdata(bus_rdata)
   );

   typedef struct {
      logic [7:0] exp;
      string      tag;
   } exp_t;

   exp_t sb[$];
   int   checks = 0;
   int   errors = 0;
   logic rd_seen = 1'b0;

   always @(posedge clk) rd_seen <= bus_re;

   // monitor: one expected item per completed read
   always @(negedge clk) begin
      exp_t e;
      if (rd_seen) begin
         checks++;
         if (sb.size() == 0) begin
            errors++;
            $display("FAIL R1 read without expectation: actual %02h expected none", bus_rdata);
         end else begin
            e = sb.pop_front();
            if (bus_rdata !== e.exp) begin
               errors++;
               $display("FAIL %s: actual %02h expected %02h", e.tag, bus_rdata, e.exp);
            end
         end
      end
   end

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr(input int a, input logic [7:0] d);
      bus_addr = AW'(a); bus_wdata = d; bus_we = 1'b1;
      @(negedge clk);
      bus_we = 1'b0;
   endtask

   task automatic rd(input int a, input logic [7:0] e, input string tag);
      sb.push_back('{exp: e, tag: tag});
      bus_addr = AW'(a); bus_re = 1'b1;
      @(negedge clk);
      bus_re = 1'b0;
   endtask

   task automatic tick();
      sec_tick = 1'b1;
      @(negedge clk);
      sec_tick = 1'b0;
      @(negedge clk);
   endtask

   task automatic set_time(input logic [7:0] y, mo, d, dw, h, mi, s);
      wr(A_CTRL, 8'h80);
      wr(A_YEAR, y); wr(A_MON, mo); wr(A_DATE, d); wr(A_DOW, dw);
      wr(A_HOUR, h); wr(A_MIN, mi); wr(A_SEC, s);
      wr(A_CTRL, 8'h00);
   endtask

   task automatic expect_time(input logic [7:0] y, mo, d, dw, h, mi, s, input string tag);
      rd(A_YEAR, y, tag); rd(A_MON, mo, tag); rd(A_DATE, d, tag); rd(A_DOW, dw, tag);
      rd(A_HOUR, h, tag); rd(A_MIN, mi, tag); rd(A_SEC, s, tag);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      idle(3);
      rst_n = 1'b1;
      idle(1);

      // R10: storage and control cleared by reset
      rd(0, 8'h00, "R10 byte 0 after reset");
      rd(A_CTRL, 8'h00, "R10 control after reset");
      rd(A_SEC, 8'h00, "R10 seconds byte after reset");
      // R10/R3: first tick mirrors reset counters advanced by one second
      tick();
      expect_time(8'h00, 8'h01, 8'h01, 8'h01, 8'h00, 8'h00, 8'h01, "R10 R3 first tick");

      // R1: plain storage
      wr(3, 8'h5A);
      wr(20, 8'hC3);
      rd(3, 8'h5A, "R1 byte 3");
      rd(20, 8'hC3, "R1 byte 20");

      // R2: address wraps modulo 48
      wr(53, 8'h77);
      rd(5, 8'h77, "R2 addr 53 -> 5");
      wr(255, 8'h99);
      rd(15, 8'h99, "R2 addr 255 -> 15");
      rd(100, 8'h00, "R2 addr 100 -> 4");

      // R7 via bit 7: tick while bit 7 set leaves clock bytes alone
      wr(A_CTRL, 8'h80);
      tick();
      rd(A_SEC, 8'h01, "R7 bit7 freeze");
      wr(A_CTRL, 8'h00);

      // R4 R5 R6: leap-year February end with every carry
      set_time(8'h24, 8'h02, 8'h28, 8'h07, 8'h23, 8'h59, 8'h59);
      tick();
      expect_time(8'h24, 8'h02, 8'h29, 8'h01, 8'h00, 8'h00, 8'h00, "R5 R6 R4 leap Feb 28");
      tick();
      expect_time(8'h24, 8'h02, 8'h29, 8'h01, 8'h00, 8'h00, 8'h01, "R5 leap Feb 29 holds");

      // R5: non-leap February
      set_time(8'h23, 8'h02, 8'h28, 8'h03, 8'h23, 8'h59, 8'h59);
      tick();
      expect_time(8'h23, 8'h03, 8'h01, 8'h04, 8'h00, 8'h00, 8'h00, "R5 non-leap Feb");

      // R5 R6: year end and century wrap
      set_time(8'h99, 8'h12, 8'h31, 8'h07, 8'h23, 8'h59, 8'h59);
      tick();
      expect_time(8'h00, 8'h01, 8'h01, 8'h01, 8'h00, 8'h00, 8'h00, "R5 R6 year wrap");

      // R5: thirty-day month
      set_time(8'h21, 8'h04, 8'h30, 8'h02, 8'h23, 8'h59, 8'h59);
      tick();
      expect_time(8'h21, 8'h05, 8'h01, 8'h03, 8'h00, 8'h00, 8'h00, "R5 April 30");

      // R4: minute carry only
      set_time(8'h21, 8'h07, 8'h15, 8'h01, 8'h10, 8'h14, 8'h59);
      tick();
      expect_time(8'h21, 8'h07, 8'h15, 8'h01, 8'h10, 8'h15, 8'h00, "R4 minute carry");

      // R7 via bit 6: bytes frozen, counters run on
      wr(A_CTRL, 8'h40);
      rd(A_CTRL, 8'h40, "R8 plain control store");
      tick();
      tick();
      rd(A_SEC, 8'h00, "R7 bit6 freeze seconds");
      rd(A_MIN, 8'h15, "R7 bit6 freeze minutes");
      // R8: clearing bit 7 when it was clear does not load
      wr(A_CTRL, 8'h00);
      tick();
      rd(A_SEC, 8'h03, "R7 R8 counters kept running, no load");

      // R11: read in the refresh cycle sees the old value
      sec_tick = 1'b1;
      @(negedge clk);
      sec_tick = 1'b0;
      rd(A_SEC, 8'h03, "R11 read during refresh cycle");
      rd(A_SEC, 8'h04, "R11 read after refresh");

      // R9: bus write beats refresh at its own byte only
      sec_tick = 1'b1;
      @(negedge clk);
      sec_tick = 1'b0;
      wr(A_SEC, 8'h42);
      rd(A_SEC, 8'h42, "R9 bus write wins");
      rd(A_MIN, 8'h15, "R9 other bytes refreshed");
      rd(A_HOUR, 8'h10, "R9 other bytes refreshed");
      tick();
      rd(A_SEC, 8'h06, "R9 counter unaffected by bus write");

      idle(3);
      if (sb.size() != 0) begin
         errors++;
         $display("FAIL R1 pending reads: actual %0d expected 0", sb.size());
      end
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule